// File: doc/BRIEF.md
# Interrupt-Capable GPIO Bank

This block is a single bank of 30 general-purpose pins behind a 32-bit register bus. Every pin can be handed to GPIO control or left with its peripheral function. Under GPIO control it drives its output data bit or is released as an input. Each pin's input is synchronized and can be read through the bus. The same synchronized input feeds a per-pin interrupt detector, which can be set to level or edge sensitivity with a chosen polarity. A hit is recorded in a sticky status bit. The bank raises one combined interrupt line, asserted while any enabled pin has its status bit set.

There is no setting that catches both edges. One polarity bit picks either the rising or the falling edge. To see every transition, software writes the pin's polarity as the inverse of its current input after each event. Status bits are cleared by writing 0 to them, so a read-modify-write clears only the bits that were just serviced.

The bus is a single-cycle request port with byte offsets. A write takes effect on the clock edge that samples the request. A read returns its data on rdata_o one cycle after the request, and that value is held until the next read.

Top module: `gpio_bank_irq`

## Requirements
- R1: After reset, direction reads 0x3FFFFFFF, meaning every pin is an input (a direction bit of 1 means input). Polarity, type, enable, status, GPIO-mode and output data all read 0. pad_oe_o and irq_o are 0 when the pads and the peripheral enables are held inactive.
- R2: The registers sit at these byte offsets: direction 0x00, polarity 0x20, type 0x30, interrupt enable 0x40, status 0x50, GPIO-mode 0x60, input data 0x70, output data 0x80. Control registers read back the value last written to them, and read data appears on rdata_o one cycle after the request.
- R3: Bits 31:30 of every register read as 0 and ignore writes. An offset outside the map reads as 0.
- R4: When a pin's GPIO-mode bit is 1, pad_oe_o is the inverse of its direction bit and pad_out_o is its output data bit. When the GPIO-mode bit is 0, the pad follows periph_out_i and periph_oe_i. periph_in_o always mirrors pad_in_i.
- R5: The input data register at 0x70 returns pad_in_i through a two-flop synchronizer. A read issued in the second cycle after a pad change still returns the old value, and the third read returns the new one. Writes to 0x70 change nothing.
- R6: With type 1 (edge), polarity 1 sets the status bit on a rising edge and polarity 0 sets it on a falling edge. The opposite edge does not set it. Status is set whether or not the interrupt is enabled, three clock edges after the pad changes.
- R7: With type 0 (level), status is set in every cycle that the synchronized input equals the polarity bit (1 = high, 0 = low). A clear written while the level persists has no lasting effect.
- R8: Writing 0 to a status bit clears it. Writing 1 leaves it unchanged, and a set status bit stays set until cleared.
- R9: irq_o is 1 exactly when some pin has both its status bit and its enable bit set. It rises in the same cycle the status bit sets and falls when the status bit is cleared.
- R10: Writing a pin's polarity as the inverse of its current input data makes its next transition set status, in either direction.
- R11: When a detected event and a clearing write to status fall in the same cycle, the status bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus request strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after the request |
| pad_in_i | input | 30 | Level sensed at each pad |
| pad_out_o | output | 30 | Value driven toward each pad |
| pad_oe_o | output | 30 | Pad output enable |
| periph_out_i | input | 30 | Peripheral output values |
| periph_oe_i | input | 30 | Peripheral output enables |
| periph_in_o | output | 30 | Pad levels passed to the peripheral |
| irq_o | output | 1 | Combined bank interrupt |

## Verification
The hardest case to reach is a status-clearing write that lands on the same clock edge as the event detected on that pin. This is the moment where software servicing one edge could lose the next. The bench counts the pipeline exactly: a pad change made at a falling edge passes two synchronizer flops and is latched on the third rising edge. The clearing write is issued two cycles after the pad change, so it commits on that third edge. The alternating-polarity sequence for catching both edges is driven purely through bus reads of the input data followed by polarity writes.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned GB_DATA_W = 32;
  localparam int unsigned GB_ADDR_W = 8;
  localparam int unsigned GB_PINS   = 30;

  typedef enum logic [GB_ADDR_W-1:0] {
    OFF_DIR  = 8'h00,
    OFF_POL  = 8'h20,
    OFF_TYPE = 8'h30,
    OFF_IEN  = 8'h40,
    OFF_STAT = 8'h50,
    OFF_OWN  = 8'h60,
    OFF_DIN  = 8'h70,
    OFF_DOUT = 8'h80
  } reg_off_e;
endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int unsigned W = 30,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= {W{RST_VAL}};
      sync_q <= {W{RST_VAL}};
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_bank_pkg::*;
#(
  parameter int unsigned N_PINS = GB_PINS,
  parameter int unsigned DATA_W = GB_DATA_W,
  parameter int unsigned ADDR_W = GB_ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [N_PINS-1:0] din_i,
  input  logic [N_PINS-1:0] stat_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [N_PINS-1:0] dir_o,
  output logic [N_PINS-1:0] pol_o,
  output logic [N_PINS-1:0] typ_o,
  output logic [N_PINS-1:0] ien_o,
  output logic [N_PINS-1:0] own_o,
  output logic [N_PINS-1:0] dout_o,
  output logic [N_PINS-1:0] stat_clr_o
);
  logic [N_PINS-1:0] dir_q, pol_q, typ_q, ien_q, own_q, dout_q;
  logic [N_PINS-1:0] wbits;
  logic              wr, rd;
  logic [DATA_W-1:0] rd_mux, rdata_q;

  assign wr    = req_i & we_i;
  assign rd    = req_i & ~we_i;
  assign wbits = wdata_i[N_PINS-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= '1;
      pol_q  <= '0;
      typ_q  <= '0;
      ien_q  <= '0;
      own_q  <= '0;
      dout_q <= '0;
    end else if (wr) begin
      if (addr_i == OFF_DIR)  dir_q  <= wbits;
      if (addr_i == OFF_POL)  pol_q  <= wbits;
      if (addr_i == OFF_TYPE) typ_q  <= wbits;
      if (addr_i == OFF_IEN)  ien_q  <= wbits;
      if (addr_i == OFF_OWN)  own_q  <= wbits;
      if (addr_i == OFF_DOUT) dout_q <= wbits;
    end
  end

  assign stat_clr_o = (wr && addr_i == OFF_STAT) ? ~wbits : '0;

  always_comb begin
    rd_mux = '0;
    unique case (addr_i)
      OFF_DIR:  rd_mux[N_PINS-1:0] = dir_q;
      OFF_POL:  rd_mux[N_PINS-1:0] = pol_q;
      OFF_TYPE: rd_mux[N_PINS-1:0] = typ_q;
      OFF_IEN:  rd_mux[N_PINS-1:0] = ien_q;
      OFF_STAT: rd_mux[N_PINS-1:0] = stat_i;
      OFF_OWN:  rd_mux[N_PINS-1:0] = own_q;
      OFF_DIN:  rd_mux[N_PINS-1:0] = din_i;
      OFF_DOUT: rd_mux[N_PINS-1:0] = dout_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (rd)  rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;
  assign dir_o   = dir_q;
  assign pol_o   = pol_q;
  assign typ_o   = typ_q;
  assign ien_o   = ien_q;
  assign own_o   = own_q;
  assign dout_o  = dout_q;

  // R2: direction write lands on the next edge
  a_r2_dir_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == OFF_DIR) |=> dir_q == $past(wbits));

  // R5: input data offset is read-only
  a_r5_din_ro: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == OFF_DIN) |=> ($stable(dir_q) && $stable(pol_q) && $stable(typ_q)
                                   && $stable(ien_q) && $stable(own_q) && $stable(dout_q)));

  // R3: unused upper bits never read back
  a_r3_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd |=> (rdata_o >> N_PINS) == '0);
endmodule

// File: rtl/gpio_irq_cell.sv
module gpio_irq_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cur_i,
  input  logic pol_i,
  input  logic typ_i,
  input  logic clr_i,
  output logic stat_o
);
  logic prev_q, stat_q, hit;

  always_comb begin
    if (typ_i) hit = pol_i ? (cur_i & ~prev_q) : (~cur_i & prev_q);
    else       hit = (cur_i == pol_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b1;
      stat_q <= 1'b0;
    end else begin
      prev_q <= cur_i;
      stat_q <= hit | (stat_q & ~clr_i);  // event beats clear
    end
  end

  assign stat_o = stat_q;

  a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q && !clr_i) |=> stat_q);
  a_r6_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (typ_i && pol_i && cur_i && !prev_q) |=> stat_q);
  a_r6_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (typ_i && !pol_i && !cur_i && prev_q) |=> stat_q);
  a_r7_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!typ_i && (cur_i == pol_i)) |=> stat_q);
  a_r11_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && typ_i && (pol_i ? (cur_i && !prev_q) : (!cur_i && prev_q))) |=> stat_q);
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int unsigned N_PINS = 30
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PINS-1:0] cur_i,
  input  logic [N_PINS-1:0] pol_i,
  input  logic [N_PINS-1:0] typ_i,
  input  logic [N_PINS-1:0] clr_i,
  output logic [N_PINS-1:0] stat_o
);
  for (genvar g = 0; g < N_PINS; g++) begin : g_pin
    gpio_irq_cell u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cur_i  (cur_i[g]),
      .pol_i  (pol_i[g]),
      .typ_i  (typ_i[g]),
      .clr_i  (clr_i[g]),
      .stat_o (stat_o[g])
    );
  end
endmodule

// File: rtl/gpio_bank_irq.sv
module gpio_bank_irq
  import gpio_bank_pkg::*;
#(
  parameter int unsigned N_PINS = GB_PINS,
  parameter int unsigned DATA_W = GB_DATA_W,
  parameter int unsigned ADDR_W = GB_ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [N_PINS-1:0] pad_in_i,
  output logic [N_PINS-1:0] pad_out_o,
  output logic [N_PINS-1:0] pad_oe_o,
  input  logic [N_PINS-1:0] periph_out_i,
  input  logic [N_PINS-1:0] periph_oe_i,
  output logic [N_PINS-1:0] periph_in_o,
  output logic              irq_o
);
  logic [N_PINS-1:0] din, stat, clr;
  logic [N_PINS-1:0] dir, pol, typ, ien, own, dout;

  gpio_sync2 #(.W(N_PINS), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_in_i),
    .q_o   (din)
  );

  gpio_regs #(.N_PINS(N_PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .we_i      (we_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .din_i     (din),
    .stat_i    (stat),
    .rdata_o   (rdata_o),
    .dir_o     (dir),
    .pol_o     (pol),
    .typ_o     (typ),
    .ien_o     (ien),
    .own_o     (own),
    .dout_o    (dout),
    .stat_clr_o(clr)
  );

  gpio_irq_detect #(.N_PINS(N_PINS)) u_detect (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cur_i (din),
    .pol_i (pol),
    .typ_i (typ),
    .clr_i (clr),
    .stat_o(stat)
  );

  assign pad_oe_o    = (own & ~dir) | (~own & periph_oe_i);
  assign pad_out_o   = (own & dout) | (~own & periph_out_i);
  assign periph_in_o = pad_in_i;
  assign irq_o       = |(stat & ien);

  // R9: disabled pins never raise the line
  a_r9_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ien == '0) |-> !irq_o);
endmodule

// File: tb/gpio_bank_irq_tb.sv
`timescale 1ns/1ps
module gpio_bank_irq_tb;
  localparam logic [31:0] M30 = 32'h3FFF_FFFF;
  localparam logic [7:0] A_DIR = 8'h00, A_POL = 8'h20, A_TYP = 8'h30, A_IEN = 8'h40,
                         A_STA = 8'h50, A_OWN = 8'h60, A_DIN = 8'h70, A_DOUT = 8'h80;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [29:0] pad_in = '1, pad_out, pad_oe, p_out = '0, p_oe = '0, p_in;
  logic        irq;
  int          n_cmp = 0, n_err = 0;

  always #2.5 clk = ~clk;

  gpio_bank_irq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pad_in_i(pad_in), .pad_out_o(pad_out),
    .pad_oe_o(pad_oe), .periph_out_i(p_out), .periph_oe_i(p_oe),
    .periph_in_o(p_in), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
    d = rdata;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic restore();
    wr(A_POL, 0); wr(A_TYP, 0); wr(A_IEN, 0); wr(A_OWN, 0); wr(A_DIR, M30);
    idle(4);
    wr(A_STA, 0);
  endtask

  task automatic t_reset();
    rd_chk("R1 dir", A_DIR, M30);
    rd_chk("R1 pol", A_POL, 0);
    rd_chk("R1 type", A_TYP, 0);
    rd_chk("R1 ien", A_IEN, 0);
    rd_chk("R1 stat", A_STA, 0);
    rd_chk("R1 own", A_OWN, 0);
    rd_chk("R1 dout", A_DOUT, 0);
    chk("R1 pad_oe", {2'b0, pad_oe}, 0);
    chk("R1 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_regs();
    wr(A_POL, 32'h1555_5555);   rd_chk("R2 pol", A_POL, 32'h1555_5555);
    wr(A_TYP, 32'h0000_F00F);   rd_chk("R2 type", A_TYP, 32'h0000_F00F);
    wr(A_IEN, 32'h0000_002A);   rd_chk("R2 ien", A_IEN, 32'h0000_002A);
    wr(A_OWN, 32'h0123_4567);   rd_chk("R2 own", A_OWN, 32'h0123_4567);
    wr(A_DIR, 32'h0F00_00F0);   rd_chk("R2 dir", A_DIR, 32'h0F00_00F0);
    wr(A_DOUT, 32'hFFFF_FFFF);  rd_chk("R3 dout upper bits", A_DOUT, M30);
    rd_chk("R3 unmapped", 8'h10, 0);
    restore();
    wr(A_DOUT, 0);
  endtask

  task automatic t_pad();
    logic [29:0] own, dir, dout;
    p_out = 30'h0F0F_0F0F; p_oe = 30'h00FF_00FF;
    @(negedge clk);
    chk("R4 periph out", {2'b0, pad_out}, {2'b0, p_out});
    chk("R4 periph oe", {2'b0, pad_oe}, {2'b0, p_oe});
    own = '1; dir = 30'h3FFF_0000; dout = 30'h1234_5678;
    wr(A_OWN, {2'b0, own}); wr(A_DIR, {2'b0, dir}); wr(A_DOUT, {2'b0, dout});
    chk("R4 gpio oe", {2'b0, pad_oe}, 32'h0000_FFFF);
    chk("R4 gpio out", {2'b0, pad_out}, {2'b0, dout});
    own = 30'h0000_0FFF;
    wr(A_OWN, {2'b0, own});
    chk("R4 mixed oe", {2'b0, pad_oe}, {2'b0, (own & ~dir) | (~own & p_oe)});
    chk("R4 mixed out", {2'b0, pad_out}, {2'b0, (own & dout) | (~own & p_out)});
    chk("R4 periph in", {2'b0, p_in}, {2'b0, pad_in});
    p_out = '0; p_oe = '0;
    wr(A_DOUT, 0);
    restore();
  endtask

  task automatic t_din();
    pad_in = 30'h2AAA_AAAA;
    rd_chk("R5 sync cycle1", A_DIN, M30);
    rd_chk("R5 sync cycle2", A_DIN, M30);
    rd_chk("R5 sync cycle3", A_DIN, 32'h2AAA_AAAA);
    wr(A_DIN, 32'h0000_1234);
    rd_chk("R5 din after write", A_DIN, 32'h2AAA_AAAA);
    rd_chk("R5 dir after din write", A_DIR, M30);
    pad_in = '1;
    restore();
  endtask

  task automatic t_edge();
    wr(A_TYP, 32'h10); wr(A_POL, 32'h10); wr(A_STA, 0);
    pad_in[4] = 1'b0; idle(4);
    rd_chk("R6 falling ignored with rise polarity", A_STA, 0);
    pad_in[4] = 1'b1; idle(4);
    rd_chk("R6 rise sets status while disabled", A_STA, 32'h10);
    chk("R6 irq stays low while disabled", {31'b0, irq}, 0);
    wr(A_POL, 0); wr(A_STA, 0);
    pad_in[4] = 1'b0; idle(4);
    rd_chk("R6 fall sets status", A_STA, 32'h10);
    wr(A_POL, 32'h10); wr(A_IEN, 32'h10); wr(A_STA, 0);
    chk("R9 irq low after clear", {31'b0, irq}, 0);
    pad_in[4] = 1'b1;
    idle(2);
    chk("R9 irq not yet (2 edges)", {31'b0, irq}, 0);
    idle(1);
    chk("R9 irq after 3 edges", {31'b0, irq}, 1);
    wr(A_STA, 32'hFFFF_FFFF);
    rd_chk("R8 write 1 keeps status", A_STA, 32'h10);
    wr(A_STA, 32'hFFFF_FFEF);
    rd_chk("R8 write 0 clears status", A_STA, 0);
    chk("R9 irq drops on clear", {31'b0, irq}, 0);
    restore();
  endtask

  task automatic t_level();
    wr(A_POL, 32'h4); idle(2);
    rd_chk("R7 high level sets", A_STA, 32'h4);
    wr(A_STA, 0);
    rd_chk("R7 clear while level held", A_STA, 32'h4);
    pad_in[2] = 1'b0; idle(4);
    wr(A_STA, 0);
    rd_chk("R8 clear after level gone", A_STA, 0);
    wr(A_POL, 0); idle(2);
    rd_chk("R7 low level sets", A_STA, 32'h4);
    pad_in[2] = 1'b1;
    restore();
  endtask

  task automatic t_both();
    logic [31:0] d;
    wr(A_TYP, 32'h80); wr(A_IEN, 32'h80);
    pad_in[7] = 1'b0; idle(4);
    rd(A_DIN, d); wr(A_POL, ~d & 32'h80); wr(A_STA, 0);
    chk("R10 armed, irq low", {31'b0, irq}, 0);
    pad_in[7] = 1'b1; idle(4);
    rd_chk("R10 rising caught", A_STA, 32'h80);
    rd(A_DIN, d); wr(A_POL, ~d & 32'h80); wr(A_STA, 0);
    chk("R10 re-armed, irq low", {31'b0, irq}, 0);
    pad_in[7] = 1'b0; idle(4);
    rd_chk("R10 falling caught", A_STA, 32'h80);
    chk("R10 irq on falling", {31'b0, irq}, 1);
    pad_in[7] = 1'b1;
    restore();
  endtask

  task automatic t_race();
    wr(A_TYP, 32'h8); wr(A_POL, 32'h8);
    pad_in[3] = 1'b0; idle(4);
    wr(A_STA, 0);
    pad_in[3] = 1'b1;
    idle(2);
    wr(A_STA, 0);  // commits on the same edge the event latches
    rd_chk("R11 event wins over clear", A_STA, 32'h8);
    restore();
  endtask

  initial begin
    #(200_000 * 5.0);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(4);
    t_reset();
    t_regs();
    t_pad();
    t_din();
    t_edge();
    t_level();
    t_both();
    t_race();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end
endmodule